// File: doc/BRIEF.md
# Precision-Truncating Memory Wrapper

This block is a synchronous single-port store of 8-bit words in which every write chooses how many of the word's most-significant bits survive. A 2-bit width code on the write selects 8, 6 or 4 retained bits. A masking stage clears the discarded low bits before the word enters the array. A 2-bit tag that records the chosen width is stored next to the word, so one array can hold words of mixed precision.

A read always returns a full 8-bit word one clock after the request. The low bits that were dropped are refilled according to the tag stored with that word, not the width code present during the read. The fill is either all zeros or a midpoint pattern: a 1 in the highest missing bit and 0 below it. A control input chosen at the read request selects the fill.

Three counters add up the bits written at each precision level, for use in energy estimates. A synchronous clear input resets them.

Top module: `prec_trunc_mem`

## Requirements
- R1: On a write, width code 2'b00 stores all 8 bits, 2'b01 clears bits [1:0] and 2'b10 clears bits [3:0] of the stored word. With zero-fill, the read returns exactly the stored word.
- R2: The reserved width code 2'b11 behaves as keep-8 in every respect: storage, fill and bit counting.
- R3: With `fill_sel`=0 at the read request, the missing low bits of the returned word are 0.
- R4: With `fill_sel`=1 at the read request, the highest missing bit is 1 and the lower missing bits are 0: bit 1 for a 6-bit word, bit 3 for a 4-bit word, and nothing for an 8-bit word.
- R5: The fill uses the width stored with the word. The `width_code` input has no effect on a read.
- R6: Read data appears one cycle after `rd_en`. `rd_valid` is high in exactly the cycle after each cycle in which `rd_en` was high.
- R7: When a read and a write address the same word in one cycle, the read returns the previous contents. The new contents are returned by a later read.
- R8: Each write with `cnt_clr` low adds 8 to `bits_k8`, 6 to `bits_k6` or 4 to `bits_k4`, according to its width code. With no write, the counters hold.
- R9: `cnt_clr` zeroes all three counters on the next edge. A write in the same cycle is not counted.
- R10: After reset, `rd_data`, `rd_valid` and all counters are 0.
- R11: `rd_data` holds its value in cycles that follow a cycle without `rd_en`, whatever `fill_sel` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| addr | input | AW | Shared word address (AW = log2 DEPTH) |
| wr_data | input | 8 | Word to store |
| width_code | input | 2 | Retained width for the write: 00 keep 8, 01 keep 6, 10 keep 4, 11 keep 8 |
| fill_sel | input | 1 | Read fill: 0 zeros, 1 midpoint pattern |
| cnt_clr | input | 1 | Synchronous clear of the bit counters |
| rd_data | output | 8 | Refilled read word, registered |
| rd_valid | output | 1 | Read data valid |
| bits_k8 | output | CW | Bits written at 8-bit precision |
| bits_k6 | output | CW | Bits written at 6-bit precision |
| bits_k4 | output | CW | Bits written at 4-bit precision |

## Verification
The properties assume that `rst_n` is asserted before any access. They assume that counter checks never straddle a wrap of a CW-bit counter, because the increment property compares modulo 2^CW. The stimulus keeps the total bits per level far below 2^16. It also reads only addresses it has already written, because the array itself carries no reset value. All inputs change on the falling edge, so each property sees stable values at the rising edge.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

    localparam int WORD_W = 8;
    localparam int TAG_W  = 2;

    typedef enum logic [TAG_W-1:0] {
        W_KEEP8 = 2'b00,
        W_KEEP6 = 2'b01,
        W_KEEP4 = 2'b10,
        W_RSVD  = 2'b11
    } width_e;

    // reserved code folds onto full width
    function automatic width_e norm_width(input logic [TAG_W-1:0] code);
        width_e w;
        w = width_e'(code);
        if (w == W_RSVD) w = W_KEEP8;
        return w;
    endfunction

    function automatic int kept_bits(input width_e w);
        case (w)
            W_KEEP6: return 6;
            W_KEEP4: return 4;
            default: return WORD_W;
        endcase
    endfunction

endpackage

// File: rtl/ptm_write_mask.sv
module ptm_write_mask
    import ptm_pkg::*;
(
    input  logic [TAG_W-1:0]  width_code,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output width_e            tag
);

    int drop;

    always_comb begin
        tag  = norm_width(width_code);
        drop = WORD_W - kept_bits(tag);
        for (int b = 0; b < WORD_W; b++) begin
            dout[b] = (b >= drop) ? din[b] : 1'b0;
        end
    end

endmodule

// File: rtl/ptm_word_store.sv
module ptm_word_store
    import ptm_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wr_word,
    input  width_e            wr_tag,
    output logic [WORD_W-1:0] rd_word,
    output width_e            rd_tag
);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        width_e            tag;
    } rd_reg_t;

    logic [WORD_W-1:0] data_mem [DEPTH];
    width_e            tag_mem  [DEPTH];

    rd_reg_t rd_d, rd_q;

    // array: no reset, written only on request
    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_mem[addr] <= wr_word;
            tag_mem[addr]  <= wr_tag;
        end
    end

    // read register samples pre-write contents
    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            rd_d.word = data_mem[addr];
            rd_d.tag  = tag_mem[addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '{word: '0, tag: W_KEEP8};
        else        rd_q <= rd_d;
    end

    assign rd_word = rd_q.word;
    assign rd_tag  = rd_q.tag;

endmodule

// File: rtl/ptm_read_fill.sv
module ptm_read_fill
    import ptm_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  width_e            tag,
    input  logic              fill_sel,
    output logic [WORD_W-1:0] dout
);

    int drop;

    always_comb begin
        drop = WORD_W - kept_bits(tag);
        for (int b = 0; b < WORD_W; b++) begin
            if (b < drop) dout[b] = fill_sel && (b == drop - 1);
            else          dout[b] = word[b];
        end
    end

endmodule

// File: rtl/ptm_bit_counters.sv
module ptm_bit_counters
    import ptm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               wr_en,
    input  width_e             tag,
    output logic [2:0][CW-1:0] cnt
);

    localparam int LEVELS = 3;

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        localparam width_e LVL  = (g == 0) ? W_KEEP8 : (g == 1) ? W_KEEP6 : W_KEEP4;
        localparam int     STEP = kept_bits(LVL);

        typedef struct packed {
            logic [CW-1:0] total;
        } cnt_t;

        cnt_t c_d, c_q;

        always_comb begin
            c_d = c_q;
            if (clr)                     c_d.total = '0;
            else if (wr_en && tag == LVL) c_d.total = c_q.total + CW'(STEP);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) c_q <= '0;
            else        c_q <= c_d;
        end

        assign cnt[g] = c_q.total;
    end

endmodule

// File: rtl/prec_trunc_mem.sv
module prec_trunc_mem
    import ptm_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [1:0]        width_code,
    input  logic              fill_sel,
    input  logic              cnt_clr,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [CW-1:0]     bits_k8,
    output logic [CW-1:0]     bits_k6,
    output logic [CW-1:0]     bits_k4
);

    typedef struct packed {
        logic valid;
        logic fill;
    } rctl_t;

    rctl_t ctl_d, ctl_q;

    logic [WORD_W-1:0] masked_word;
    width_e            wr_tag;
    logic [WORD_W-1:0] raw_word;
    width_e            raw_tag;
    logic [2:0][CW-1:0] cnt;

    ptm_write_mask u_mask (
        .width_code (width_code),
        .din        (wr_data),
        .dout       (masked_word),
        .tag        (wr_tag)
    );

    ptm_word_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wr_word (masked_word),
        .wr_tag  (wr_tag),
        .rd_word (raw_word),
        .rd_tag  (raw_tag)
    );

    // fill mode is captured with the request so the output holds between reads
    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.valid = rd_en;
        if (rd_en) ctl_d.fill = fill_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    ptm_read_fill u_fill (
        .word     (raw_word),
        .tag      (raw_tag),
        .fill_sel (ctl_q.fill),
        .dout     (rd_data)
    );

    ptm_bit_counters #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .wr_en (wr_en),
        .tag   (wr_tag),
        .cnt   (cnt)
    );

    assign rd_valid = ctl_q.valid;
    assign bits_k8  = cnt[0];
    assign bits_k6  = cnt[1];
    assign bits_k4  = cnt[2];

endmodule

// File: rtl/prec_trunc_mem_chk.sv
module prec_trunc_mem_chk #(
    parameter int AW = 4,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic [AW-1:0] addr,
    input logic [7:0]    wr_data,
    input logic [1:0]    width_code,
    input logic          fill_sel,
    input logic          cnt_clr,
    input logic [7:0]    rd_data,
    input logic          rd_valid,
    input logic [CW-1:0] bits_k8,
    input logic [CW-1:0] bits_k6,
    input logic [CW-1:0] bits_k4
);

    // R6
    rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R6
    rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R11
    rd_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R9
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (bits_k8 == '0 && bits_k6 == '0 && bits_k4 == '0));

    // R8
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clr && !wr_en) |=> ($stable(bits_k8) && $stable(bits_k6) && $stable(bits_k4)));

    // R8
    cnt_k6_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cnt_clr && width_code == 2'b01) |=> bits_k6 == $past(bits_k6) + CW'(6));

    // R2
    cnt_rsvd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cnt_clr && width_code == 2'b11) |=> bits_k8 == $past(bits_k8) + CW'(8));

endmodule

bind prec_trunc_mem prec_trunc_mem_chk #(.AW(AW), .CW(CW)) u_chk (.*);

// File: tb/prec_trunc_mem_bench.sv
module prec_trunc_mem_bench;

    localparam int AW = 4;
    localparam int CW = 16;
    localparam int NV = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wr_data = '0;
    logic [1:0]    width_code = '0;
    logic          fill_sel = 1'b0;
    logic          cnt_clr = 1'b0;
    logic [7:0]    rd_data;
    logic          rd_valid;
    logic [CW-1:0] bits_k8, bits_k6, bits_k4;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    prec_trunc_mem #(.DEPTH(16), .CW(CW)) u_prec_trunc_mem (.*);

    // {addr[3:0], code[1:0], data, expect zero-fill, expect pattern-fill}
    localparam logic [29:0] VEC [NV] = '{
        {4'd0, 2'b00, 8'hA7, 8'hA7, 8'hA7},
        {4'd1, 2'b01, 8'hA7, 8'hA4, 8'hA6},
        {4'd2, 2'b10, 8'hA7, 8'hA0, 8'hA8},
        {4'd3, 2'b11, 8'h5B, 8'h5B, 8'h5B},
        {4'd4, 2'b01, 8'hFF, 8'hFC, 8'hFE},
        {4'd5, 2'b10, 8'h0F, 8'h00, 8'h08},
        {4'd6, 2'b10, 8'hF3, 8'hF0, 8'hF8},
        {4'd7, 2'b01, 8'h03, 8'h00, 8'h02}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d, input logic [1:0] c);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d; width_code = c;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // rd_data is sampled on the falling edge after the capturing rising edge
    task automatic do_read(input logic [AW-1:0] a, input logic f, input logic [1:0] c);
        @(negedge clk);
        rd_en = 1'b1; addr = a; fill_sel = f; width_code = c;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 rd_data", rd_data, 0);
        check("R10 rd_valid", rd_valid, 0);
        check("R10 bits_k8", bits_k8, 0);
        check("R10 bits_k4", bits_k4, 0);
        rst_n = 1'b1;

        // R1 R2 R3 R4: table walk
        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][29:26], VEC[i][23:16], VEC[i][25:24]);
        end
        for (int i = 0; i < NV; i++) begin
            do_read(VEC[i][29:26], 1'b0, 2'b00);
            check("R1/R3 zero fill", rd_data, VEC[i][15:8]);
            check("R6 rd_valid", rd_valid, 1);
            do_read(VEC[i][29:26], 1'b1, 2'b00);
            check("R4 pattern fill", rd_data, VEC[i][7:0]);
        end

        // R8 and R2: codes 00+11 give 16, three 01 writes 18, three 10 writes 12
        check("R8 bits_k8", bits_k8, 16);
        check("R8 bits_k6", bits_k6, 18);
        check("R8 bits_k4", bits_k4, 12);

        // R5: width_code during read ignored; word 1 holds keep-6
        do_read(4'd1, 1'b1, 2'b10);
        check("R5 stored tag used", rd_data, 8'hA6);
        do_read(4'd2, 1'b1, 2'b00);
        check("R5 stored tag used", rd_data, 8'hA8);

        // R11: idle cycles with fill_sel toggling keep output
        fill_sel = 1'b0;
        @(negedge clk);
        check("R11 hold", rd_data, 8'hA8);
        check("R6 no valid", rd_valid, 0);
        fill_sel = 1'b1;
        @(negedge clk);
        check("R11 hold", rd_data, 8'hA8);

        // R7: read and write same word same cycle
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = 4'd0; wr_data = 8'h3C; width_code = 2'b10; fill_sel = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R7 old contents", rd_data, 8'hA7);
        do_read(4'd0, 1'b1, 2'b00);
        check("R7 new contents", rd_data, 8'h38);

        // R9: clear wins over simultaneous write
        @(negedge clk);
        cnt_clr = 1'b1; wr_en = 1'b1; addr = 4'd9; wr_data = 8'h11; width_code = 2'b01;
        @(negedge clk);
        cnt_clr = 1'b0; wr_en = 1'b0;
        check("R9 bits_k6", bits_k6, 0);
        check("R9 bits_k4", bits_k4, 0);
        check("R9 bits_k8", bits_k8, 0);

        // R2: reserved code counts as 8 after clear
        do_write(4'd10, 8'hC3, 2'b11);
        check("R2 bits_k8", bits_k8, 8);
        do_read(4'd10, 1'b1, 2'b00);
        check("R2 full width", rd_data, 8'hC3);

        // R8: no write, counters hold
        @(negedge clk);
        check("R8 hold", bits_k8, 8);

        done = 1'b1;
        finish_run();
    end

endmodule